// File: doc/BRIEF.md
# Byte-Accessed 16-Bit Up/Down Counter

A 16-bit timer counter that a processor reaches through an 8-bit bus. The count is visible at two byte addresses. A temporary high-byte register stands between the bus and the upper half of the counter, so that a full 16-bit value can be read or written without tearing. Reading the low byte captures the matching high byte into the temporary register, where a later high-byte read finds it. The high byte is written into the temporary register first. A low-byte write then loads all sixteen bits in one clock.

Counting advances on a tick from an external clock-select stage, and only while the 3-bit clock-select field is non-zero. There are two count sequences. One wraps upward through the whole 16-bit range. The other ramps up to a programmable top value and back down to zero. Either sequence raises a sticky overflow flag, which the processor clears through a status address. The block drives two comparator outputs: one for the top value and one for zero.

Top module: `bytebus_counter`

## Requirements
- R1: After the asynchronous active-low reset, the counter, the temporary register and the overflow flag are zero, and the up/down sequence faces upward.
- R2: `addr_i` selects the register: 0 is the counter low byte, 1 is the temporary high-byte register, 2 is the status byte with the overflow flag in bit 0, and 3 reads as zero. `rdata_o` shows the selected register combinationally in the same cycle.
- R3: A read strobe at address 0 copies the counter's upper byte into the temporary register at that clock edge. A later read at address 1 returns that captured byte, even if the counter has moved since.
- R4: A write at address 1 loads only the temporary register and leaves the counter unchanged.
- R5: A write at address 0 loads the counter with {temporary register, write data} at that edge. This load takes priority over any clear or count request in the same cycle.
- R6: While `clk_sel_i` is 0, ticks are ignored and the counter holds. Bus reads and writes still work.
- R7: An enabled tick (`tick_i` high and `clk_sel_i` non-zero) with `clear_i` high sets the counter to zero and does not set the overflow flag.
- R8: With `mode_i` = 0, each enabled tick adds one. From 0xFFFF the counter wraps to 0 and sets the overflow flag.
- R9: With `mode_i` = 1, an enabled tick behaves as follows. At zero, the counter steps to 1 and faces upward, or holds if `top_i` is 0. Facing upward below `top_i`, it adds one. Otherwise it subtracts one and faces downward. A step from 1 to 0 sets the overflow flag and turns the counter upward again.
- R10: `top_o` is high exactly when the count equals `top_i`. `bottom_o` is high exactly when the count is zero.
- R11: A write at address 2 with data bit 0 set clears the overflow flag. A write with bit 0 clear has no effect. A hardware set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Register select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| tick_i | input | 1 | Count tick from the clock-select stage |
| clk_sel_i | input | 3 | Clock-select field, 0 stops counting |
| mode_i | input | 1 | 0 = wrap upward, 1 = up/down to top |
| clear_i | input | 1 | Clear the count on the next enabled tick |
| top_i | input | 16 | Top value for the up/down sequence |
| top_o | output | 1 | Count equals top value |
| bottom_o | output | 1 | Count equals zero |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The counter, the temporary register and the overflow flag all update at the clock edge on which the stimulus is sampled. Their effects are therefore due one edge later. `rdata_o`, `top_o` and `bottom_o` follow that state with no further delay. The bench drives inputs on the falling edge and advances its behavioural model at the rising edge from the same inputs. It compares every output at the next falling edge, so each result is checked in the cycle it becomes due. A captured high byte is checked only by a later read at address 1, after the counter has moved on.

// File: rtl/bytebus_counter_pkg.sv
package bytebus_counter_pkg;
  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_HI   = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic {
    MODE_WRAP   = 1'b0,
    MODE_UPDOWN = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/bbc_bus_port.sv
module bbc_bus_port
  import bytebus_counter_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              ovf_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [BYTE_W-1:0] temp_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              ovf_clr_o
);
  reg_sel_e          sel;
  logic [BYTE_W-1:0] temp_q;

  assign sel = reg_sel_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      temp_q <= '0;
    end else if (wr_i && sel == SEL_HI) begin
      temp_q <= wdata_i;
    end else if (rd_i && sel == SEL_LO) begin
      temp_q <= cnt_i[CNT_W-1:BYTE_W];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_LO:   rdata_o = cnt_i[BYTE_W-1:0];
      SEL_HI:   rdata_o = temp_q;
      SEL_STAT: rdata_o = {{(BYTE_W-1){1'b0}}, ovf_i};
      default:  rdata_o = '0;
    endcase
  end

  assign temp_o     = temp_q;
  assign load_o     = wr_i && sel == SEL_LO;
  assign load_val_o = {temp_q, wdata_i};
  assign ovf_clr_o  = wr_i && sel == SEL_STAT && wdata_i[0];
endmodule

// File: rtl/bbc_count_core.sv
module bbc_count_core
  import bytebus_counter_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] clk_sel_i,
  input  logic             mode_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] top_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_set_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d;
  logic             step_en;
  cnt_mode_e        mode;

  assign mode    = cnt_mode_e'(mode_i);
  assign step_en = tick_i && (clk_sel_i != '0) && !load_i;

  always_comb begin
    cnt_d     = cnt_q;
    up_d      = up_q;
    ovf_set_o = 1'b0;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (step_en) begin
      if (clear_i) begin
        cnt_d = '0;
      end else if (mode == MODE_WRAP) begin
        cnt_d     = cnt_q + ONE;
        ovf_set_o = (cnt_q == '1);
      end else if (cnt_q == '0) begin
        if (top_i != '0) begin
          cnt_d = ONE;
          up_d  = 1'b1;
        end
      end else if (up_q && cnt_q < top_i) begin
        cnt_d = cnt_q + ONE;
      end else begin
        cnt_d = cnt_q - ONE;
        up_d  = 1'b0;
        if (cnt_q == ONE) begin
          ovf_set_o = 1'b1;
          up_d      = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/bbc_ovf_flag.sv
module bbc_ovf_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/bytebus_counter.sv
module bytebus_counter
  import bytebus_counter_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SEL_W  = 3,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              tick_i,
  input  logic [SEL_W-1:0]  clk_sel_i,
  input  logic              mode_i,
  input  logic              clear_i,
  input  logic [CNT_W-1:0]  top_i,
  output logic              top_o,
  output logic              bottom_o,
  output logic              ovf_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  load_val;
  logic [BYTE_W-1:0] temp_q;
  logic              load, ovf_set, ovf_clr, ovf_q;

  bbc_bus_port #(.BYTE_W(BYTE_W)) u_bus (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .wdata_i    (wdata_i),
    .cnt_i      (cnt_q),
    .ovf_i      (ovf_q),
    .rdata_o    (rdata_o),
    .temp_o     (temp_q),
    .load_o     (load),
    .load_val_o (load_val),
    .ovf_clr_o  (ovf_clr)
  );

  bbc_count_core #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .tick_i     (tick_i),
    .clk_sel_i  (clk_sel_i),
    .mode_i     (mode_i),
    .clear_i    (clear_i),
    .top_i      (top_i),
    .cnt_o      (cnt_q),
    .ovf_set_o  (ovf_set)
  );

  bbc_ovf_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ovf_set),
    .clr_i  (ovf_clr),
    .flag_o (ovf_q)
  );

  assign top_o    = (cnt_q == top_i);
  assign bottom_o = (cnt_q == '0);
  assign ovf_o    = ovf_q;
endmodule

// File: rtl/bytebus_counter_chk.sv
module bytebus_counter_chk #(
  parameter int BYTE_W = 8,
  parameter int SEL_W  = 3,
  localparam int CNT_W = 2 * BYTE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [BYTE_W-1:0] wdata_i,
  input logic              tick_i,
  input logic [SEL_W-1:0]  clk_sel_i,
  input logic              mode_i,
  input logic              clear_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [BYTE_W-1:0] temp_i,
  input logic              ovf_i,
  input logic              ovf_set_i
);
  logic lo_wr, en;
  assign lo_wr = wr_i && addr_i == 2'd0;
  assign en    = tick_i && clk_sel_i != '0 && !lo_wr;

  a_r5_low_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_wr |=> cnt_i == $past({temp_i, wdata_i}));

  a_r4_high_to_temp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == 2'd1 |=> temp_i == $past(wdata_i));

  a_r6_stopped_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_sel_i == '0 && !lo_wr |=> $stable(cnt_i));

  a_r3_snapshot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == 2'd0 && !wr_i |=> temp_i == $past(cnt_i[CNT_W-1:BYTE_W]));

  a_r7_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && clear_i |=> cnt_i == '0);

  a_r7_clear_no_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && clear_i |-> !ovf_set_i);

  a_r8_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && !clear_i && !mode_i && cnt_i == '1 |=> cnt_i == '0 && ovf_i);

  a_r11_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_set_i |=> ovf_i);

  a_r11_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == 2'd2 && wdata_i[0] && !ovf_set_i |=> !ovf_i);
endmodule

bind bytebus_counter bytebus_counter_chk #(.BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wr_i      (wr_i),
  .rd_i      (rd_i),
  .wdata_i   (wdata_i),
  .tick_i    (tick_i),
  .clk_sel_i (clk_sel_i),
  .mode_i    (mode_i),
  .clear_i   (clear_i),
  .cnt_i     (cnt_q),
  .temp_i    (temp_q),
  .ovf_i     (ovf_q),
  .ovf_set_i (ovf_set)
);

// File: tb/bytebus_counter_bench.sv
module bytebus_counter_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        tick = 1'b0;
  logic [2:0]  clk_sel = '0;
  logic        mode = 1'b0;
  logic        clear = 1'b0;
  logic [15:0] top = '0;
  logic        top_o, bottom_o, ovf_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R1";

  int m_cnt = 0, m_temp = 0, m_ovf = 0, m_up = 1;

  always #(CLK_P/2) clk = ~clk;

  bytebus_counter u_bytebus_counter (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .clk_sel_i(clk_sel),
    .mode_i(mode), .clear_i(clear), .top_i(top), .top_o(top_o),
    .bottom_o(bottom_o), .ovf_o(ovf_o)
  );

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    int nt, set;
    bit lo_wr, en;
    lo_wr = wr && addr == 2'd0;
    en    = tick && clk_sel != 0 && !lo_wr;
    nt    = m_temp;
    set   = 0;
    if (rd && addr == 2'd0) nt = m_cnt / 256;
    if (wr && addr == 2'd1) nt = wdata;
    if (lo_wr) m_cnt = m_temp * 256 + wdata;
    else if (en) begin
      if (clear) m_cnt = 0;
      else if (!mode) begin
        if (m_cnt == 65535) begin m_cnt = 0; set = 1; end
        else m_cnt++;
      end else if (m_cnt == 0) begin
        if (top != 0) begin m_cnt = 1; m_up = 1; end
      end else if (m_up == 1 && m_cnt < int'(top)) m_cnt++;
      else begin
        m_cnt--;
        m_up = 0;
        if (m_cnt == 0) begin set = 1; m_up = 1; end
      end
    end
    if (set == 1) m_ovf = 1;
    else if (wr && addr == 2'd2 && wdata[0]) m_ovf = 0;
    m_temp = nt;
  endtask

  task automatic compare();
    int exp_rd;
    case (addr)
      2'd0: exp_rd = m_cnt % 256;
      2'd1: exp_rd = m_temp;
      2'd2: exp_rd = m_ovf;
      default: exp_rd = 0;
    endcase
    check(cur_req, "rdata (R2)", int'(rdata), exp_rd);
    check(cur_req, "top_o (R10)", int'(top_o), int'(m_cnt == int'(top)));
    check(cur_req, "bottom_o (R10)", int'(bottom_o), int'(m_cnt == 0));
    check(cur_req, "ovf_o", int'(ovf_o), m_ovf);
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      if (rst_ni) model_step();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    addr = a; wr = 1'b1; wdata = d;
    cyc();
    wr = 1'b0;
  endtask

  task automatic bus_rd(logic [1:0] a);
    addr = a; rd = 1'b1;
    cyc();
    rd = 1'b0;
  endtask

  task automatic load16(int v);
    bus_wr(2'd1, 8'(v / 256));
    bus_wr(2'd0, 8'(v % 256));
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    cur_req = "R1";
    compare();
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a);
      #1;
      check("R1", "reset rdata", int'(rdata), 0);
    end
    check("R1", "reset bottom_o", int'(bottom_o), 1);
    cyc(2);

    // R4 high write touches temp only
    cur_req = "R4";
    clk_sel = 3'd0;
    bus_wr(2'd1, 8'h12);
    addr = 2'd0; #1;
    check("R4", "low byte after high write", int'(rdata), 0);
    addr = 2'd1; #1;
    check("R4", "temp after high write", int'(rdata), 8'h12);
    cyc();

    // R5 low write wins over clear and tick
    cur_req = "R5";
    clk_sel = 3'd1; tick = 1'b1; clear = 1'b1;
    bus_wr(2'd0, 8'h34);
    tick = 1'b0; clear = 1'b0;
    check("R5", "low byte after load", int'(m_cnt), 16'h1234);
    addr = 2'd0; #1;
    check("R5", "rdata low after load", int'(rdata), 8'h34);

    // R6 stopped clock select
    cur_req = "R6";
    clk_sel = 3'd0; tick = 1'b1;
    cyc(20);
    addr = 2'd0; #1;
    check("R6", "low byte held", int'(rdata), 8'h34);
    load16(16'h0A0B);
    addr = 2'd0; #1;
    check("R6", "load while stopped", int'(rdata), 8'h0B);
    tick = 1'b0;

    // R8 wrap mode and overflow
    cur_req = "R8";
    mode = 1'b0; clk_sel = 3'd4;
    load16(16'hFFFE);
    tick = 1'b1;
    cyc(3);
    tick = 1'b0;
    check("R8", "ovf after wrap", int'(ovf_o), 1);
    addr = 2'd0; #1;
    check("R8", "low byte after wrap", int'(rdata), 1);

    // R11 clear rules
    cur_req = "R11";
    bus_wr(2'd2, 8'hFE);
    check("R11", "write 0 keeps flag", int'(ovf_o), 1);
    bus_wr(2'd2, 8'h01);
    check("R11", "write 1 clears flag", int'(ovf_o), 0);
    load16(16'hFFFF);
    tick = 1'b1;
    bus_wr(2'd2, 8'h01);
    tick = 1'b0;
    check("R11", "set beats clear", int'(ovf_o), 1);
    bus_wr(2'd2, 8'h01);

    // R3 snapshot
    cur_req = "R3";
    load16(16'h01FF);
    tick = 1'b1;
    bus_rd(2'd0);
    tick = 1'b0;
    cyc(2);
    addr = 2'd1; #1;
    check("R3", "captured high byte", int'(rdata), 8'h01);
    cyc();

    // R7 clear
    cur_req = "R7";
    load16(16'h4321);
    tick = 1'b1; clear = 1'b1;
    cyc();
    clear = 1'b0; tick = 1'b0;
    check("R7", "count cleared", int'(bottom_o), 1);
    check("R7", "no overflow on clear", int'(ovf_o), 0);

    // R9 up/down
    cur_req = "R9";
    mode = 1'b1; top = 16'd5; tick = 1'b1;
    cyc(25);
    tick = 1'b0;
    check("R9", "overflow in up/down", int'(ovf_o), 1);
    bus_wr(2'd2, 8'h01);
    top = 16'd0; tick = 1'b1;
    load16(0);
    cyc(5);
    check("R9", "hold at zero with top 0", int'(bottom_o), 1);
    top = 16'd3;
    load16(16'd9);
    cyc(15);
    top = 16'd1;
    cyc(6);
    tick = 1'b0;
    bus_wr(2'd2, 8'h01);

    // R10 and mixed random traffic
    cur_req = "R10";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      addr    = 2'($urandom_range(0, 3));
      wr      = (r < 8);
      rd      = (r >= 8 && r < 20);
      wdata   = 8'($urandom);
      tick    = ($urandom_range(0, 3) != 0);
      clear   = ($urandom_range(0, 60) == 0);
      clk_sel = 3'($urandom_range(0, 4));
      if (i % 500 == 0) begin
        mode = ~mode;
        top  = 16'($urandom_range(0, 40));
      end
      cyc();
    end
    wr = 1'b0; rd = 1'b0; tick = 1'b0; clear = 1'b0;
    cyc(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule